// File: doc/BRIEF.md
# Strobe Watchdog with Selectable Timeout

This block watches a strobe line that a processor toggles from one of its general-purpose pins. Each high-to-low transition of the strobe starts a fresh timeout window, measured in millisecond ticks. If no falling edge arrives before the window runs out, the block emits a one-cycle reset request to a shared reset stretcher. That stretcher produces the long reset pulse and, while it is active, holds the watchdog cleared through the `hold_clear` input. If the processor never strobes again, the block sends another request one window after each release, so reset pulses keep coming once per period.

The window length comes from a 2-bit code. A separate pad decoder produces this code from a three-level select pin, which can be driven low, left floating or driven high. The preset lengths are 150, 600 and 1200 ticks, and all three are parameters. The strobe is asynchronous to the clock. It passes through a synchronizer before edge detection, so each strobe level must be held for more than two clock periods of the chosen clock to be seen. A new select code takes effect only when the window restarts.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst_n` is low, `wd_req` is 0. After release, no request is raised until a full window has elapsed.
- R2: A falling edge on `wd_strobe` restarts the window, provided each level is held at least three clock cycles. Falling edges spaced closer than the window keep `wd_req` at 0 indefinitely.
- R3: Rising edges and static levels on `wd_strobe` do not restart the window. With no falling edge, the spacing between requests stays exactly one window.
- R4: The window length in ticks follows the code on `period_sel`: 2'b00 gives SHORT_TICKS, 2'b01 gives MID_TICKS, 2'b10 gives LONG_TICKS, and 2'b11 gives LONG_TICKS (or SHORT_TICKS when SPARE_IS_LONG is 0). The request is raised after the last tick of the window.
- R5: `wd_req` is high for exactly one clock cycle per timeout.
- R6: While `hold_clear` is high, `wd_req` stays 0 and the window is cleared. A fresh, full window starts one cycle after `hold_clear` falls.
- R7: Without strobes and with `hold_clear` low, a new request follows every window. With the tick every K cycles and a window of P ticks, consecutive requests are K*P cycles apart.
- R8: A change of `period_sel` does not alter a running window. The new length is loaded at the next restart or timeout.
- R9: A window advances only on `ms_tick`. With no ticks, no request is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| wd_strobe | input | 1 | Asynchronous strobe from the processor; its falling edges restart the window |
| period_sel | input | 2 | Decoded window-length code |
| hold_clear | input | 1 | High while any other reset source is active; clears the window |
| wd_req | output | 1 | One-cycle reset request to the stretcher |

## Verification
The bench first lets the strobe sit high and then low under each of the four select codes. The exact spacing between requests shows both the decoded window length and the repetition, and it separates a correct decode from one that swaps or miscounts a code. Select changes made in the middle of a window show whether the old length finishes before the new one applies. A lone rising edge and a steady stream of falling edges closer than the window separate true falling-edge detection from level or any-edge detection. Phases with hold asserted and with ticks stopped show that neither the clearing path nor the tick gate ever lets a request leak out.

// File: rtl/strobe_wd_pkg.sv
package strobe_wd_pkg;

   // Window-length codes delivered by the three-level pad decoder
   typedef enum logic [1:0] {
      WIN_SHORT = 2'b00,
      WIN_MID   = 2'b01,
      WIN_LONG  = 2'b10,
      WIN_SPARE = 2'b11
   } win_code_e;

endpackage

// File: rtl/swd_fall_detect.sv
module swd_fall_detect #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("swd_fall_detect: STAGES must be at least 2");
      end
   endgenerate

   // Synchronizer chain, then one extra flop for edge comparison
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], strobe_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign fall_o = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/swd_period_decode.sv
module swd_period_decode
   import strobe_wd_pkg::*;
#(
   parameter int CNT_W         = 11,
   parameter int SHORT_TICKS   = 150,
   parameter int MID_TICKS     = 600,
   parameter int LONG_TICKS    = 1200,
   parameter bit SPARE_IS_LONG = 1'b1
) (
   input  logic [1:0]       code_i,
   output logic [CNT_W-1:0] limit_o
);

   localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(SHORT_TICKS);
   localparam logic [CNT_W-1:0] LIM_MID   = CNT_W'(MID_TICKS);
   localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(LONG_TICKS);

   logic [CNT_W-1:0] spare_lim;

   generate
      if (SPARE_IS_LONG) begin : g_spare_long
         assign spare_lim = LIM_LONG;
      end else begin : g_spare_short
         assign spare_lim = LIM_SHORT;
      end
   endgenerate

   always_comb begin
      unique case (win_code_e'(code_i))
         WIN_SHORT: limit_o = LIM_SHORT;
         WIN_MID:   limit_o = LIM_MID;
         WIN_LONG:  limit_o = LIM_LONG;
         default:   limit_o = spare_lim;
      endcase
   end

endmodule

// File: rtl/swd_window_counter.sv
module swd_window_counter #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_i,
   input  logic             restart_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             expire_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_q;
   logic             expire_q;
   logic             last_tick;

   assign last_tick = (cnt_q == lim_q - ONE);

   // Disarmed state lasts one cycle and latches the window length
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         cnt_q    <= '0;
         lim_q    <= '0;
         expire_q <= 1'b0;
      end else begin
         expire_q <= 1'b0;
         if (hold_i) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
         end else if (!armed_q) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
            lim_q   <= limit_i;
         end else if (restart_i) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
         end else if (tick_i) begin
            if (last_tick) begin
               expire_q <= 1'b1;
               armed_q  <= 1'b0;
               cnt_q    <= '0;
            end else begin
               cnt_q <= cnt_q + ONE;
            end
         end
      end
   end

   assign expire_o = expire_q;

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
   parameter int SHORT_TICKS   = 150,
   parameter int MID_TICKS     = 600,
   parameter int LONG_TICKS    = 1200,
   parameter bit SPARE_IS_LONG = 1'b1,
   parameter int SYNC_STAGES   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ms_tick,
   input  logic       wd_strobe,
   input  logic [1:0] period_sel,
   input  logic       hold_clear,
   output logic       wd_req
);

   localparam int CNT_W = $clog2(LONG_TICKS + 1);

   generate
      if (SHORT_TICKS < 1) begin : g_bad_short
         $error("strobe_watchdog: SHORT_TICKS must be at least 1");
      end
      if ((MID_TICKS < SHORT_TICKS) || (LONG_TICKS < MID_TICKS)) begin : g_bad_order
         $error("strobe_watchdog: window lengths must be non-decreasing");
      end
   endgenerate

   logic             fall_w;
   logic [CNT_W-1:0] limit_w;

   swd_fall_detect #(
      .STAGES(SYNC_STAGES)
   ) u_fall (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (wd_strobe),
      .fall_o   (fall_w)
   );

   swd_period_decode #(
      .CNT_W         (CNT_W),
      .SHORT_TICKS   (SHORT_TICKS),
      .MID_TICKS     (MID_TICKS),
      .LONG_TICKS    (LONG_TICKS),
      .SPARE_IS_LONG (SPARE_IS_LONG)
   ) u_dec (
      .code_i  (period_sel),
      .limit_o (limit_w)
   );

   swd_window_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_i    (hold_clear),
      .restart_i (fall_w),
      .tick_i    (ms_tick),
      .limit_i   (limit_w),
      .expire_o  (wd_req)
   );

endmodule

// File: rtl/strobe_watchdog_chk.sv
module strobe_watchdog_chk (
   input logic clk,
   input logic rst_n,
   input logic ms_tick,
   input logic hold_clear,
   input logic fall,
   input logic wd_req
);

   // R1: no request while reset is held
   always @(negedge clk) begin
      if (rst_n === 1'b0) begin
         assert_reset_quiet_R1: assert (wd_req === 1'b0);
      end
   end

   // R2: a detected falling edge never coincides with a timeout
   assert_fall_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !wd_req);

   // R5: request lasts one cycle
   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wd_req |=> !wd_req);

   // R6: clearing input suppresses requests
   assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_clear |=> !wd_req);

   // R9: a request only follows a tick
   assert_tick_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ms_tick |=> !wd_req);

endmodule

bind strobe_watchdog strobe_watchdog_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ms_tick    (ms_tick),
   .hold_clear (hold_clear),
   .fall       (fall_w),
   .wd_req     (wd_req)
);

// File: tb/strobe_watchdog_tb_top.sv
`timescale 1ns/1ps
module strobe_watchdog_tb_top;

   localparam int P_SHORT = 5;
   localparam int P_MID   = 9;
   localparam int P_LONG  = 14;
   localparam int K       = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ms_tick = 1'b0;
   logic       wd_strobe = 1'b1;
   logic [1:0] period_sel = 2'b00;
   logic       hold_clear = 1'b0;
   logic       wd_req;

   int    n_chk = 0;
   int    n_err = 0;
   int    cyc = 0;
   bit    tick_en = 1'b0;
   string phase = "R1";

   always #4 clk = ~clk;

   strobe_watchdog #(
      .SHORT_TICKS   (P_SHORT),
      .MID_TICKS     (P_MID),
      .LONG_TICKS    (P_LONG),
      .SPARE_IS_LONG (1'b1),
      .SYNC_STAGES   (2)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ms_tick    (ms_tick),
      .wd_strobe  (wd_strobe),
      .period_sel (period_sel),
      .hold_clear (hold_clear),
      .wd_req     (wd_req)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic int period_of(input logic [1:0] c);
      case (c)
         2'b00:   return P_SHORT;
         2'b01:   return P_MID;
         default: return P_LONG;
      endcase
   endfunction

   // Reference model
   int sh[$];
   int m_armed, m_cnt, m_lim, m_req;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh = '{0, 0, 0};
         m_armed = 0; m_cnt = 0; m_lim = 0; m_req = 0;
      end else begin
         int fall_now;
         cyc++;
         fall_now = (sh[2] == 1 && sh[1] == 0);
         sh.push_front(int'(wd_strobe));
         void'(sh.pop_back());
         m_req = 0;
         if (hold_clear) begin
            m_armed = 0; m_cnt = 0;
         end else if (m_armed == 0) begin
            m_lim = period_of(period_sel); m_cnt = 0; m_armed = 1;
         end else if (fall_now != 0) begin
            m_armed = 0; m_cnt = 0;
         end else if (ms_tick) begin
            if (m_cnt == m_lim - 1) begin
               m_req = 1; m_armed = 0; m_cnt = 0;
            end else begin
               m_cnt++;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) check(wd_req === m_req[0], phase, int'(wd_req), m_req);
      ms_tick <= tick_en && (cyc % K == 0);
   end

   task automatic wait_pulse(output int at);
      at = -1;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (wd_req) begin
            at = cyc;
            break;
         end
      end
      if (at < 0) check(1'b0, phase, 0, 1);
   endtask

   task automatic count_pulses(input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (wd_req) cnt++;
      end
   endtask

   task automatic gap_check(input string req, input int exp_gap, inout int prev);
      int now;
      wait_pulse(now);
      check((now - prev) == exp_gap, req, now - prev, exp_gap);
      prev = now;
   endtask

   initial begin
      int t, c;
      repeat (5) @(negedge clk);
      check(wd_req === 1'b0, "R1", int'(wd_req), 0);
      rst_n = 1'b1;
      tick_en = 1'b1;
      // R1: nothing before a whole window has elapsed
      count_pulses(K * (P_SHORT - 1), c);
      check(c == 0, "R1", c, 0);
      phase = "R4";
      wait_pulse(t);
      @(negedge clk);
      check(wd_req === 1'b0, "R5", int'(wd_req), 0);
      gap_check("R4", K * P_SHORT, t);
      phase = "R7";
      gap_check("R7", K * P_SHORT, t);
      // R8: change select mid-window
      phase = "R8";
      repeat (3) @(negedge clk);
      period_sel = 2'b01;
      gap_check("R8", K * P_SHORT, t);
      gap_check("R4", K * P_MID, t);
      repeat (3) @(negedge clk);
      period_sel = 2'b10;
      gap_check("R8", K * P_MID, t);
      gap_check("R4", K * P_LONG, t);
      repeat (3) @(negedge clk);
      period_sel = 2'b11;
      gap_check("R4", K * P_LONG, t);
      gap_check("R4", K * P_LONG, t);
      repeat (3) @(negedge clk);
      period_sel = 2'b00;
      gap_check("R8", K * P_LONG, t);
      // R3: a falling edge, then rising edge and static levels
      phase = "R3";
      repeat (3) @(negedge clk);
      wd_strobe = 1'b0;
      wait_pulse(t);
      repeat (6) @(negedge clk);
      wd_strobe = 1'b1;
      gap_check("R3", K * P_SHORT, t);
      gap_check("R3", K * P_SHORT, t);
      // R2: falling edges every 12 cycles, window is 20 cycles
      phase = "R2";
      begin
         int tot = 0;
         for (int i = 0; i < 20; i++) begin
            wd_strobe = 1'b0;
            count_pulses(6, c); tot += c;
            wd_strobe = 1'b1;
            count_pulses(6, c); tot += c;
         end
         check(tot == 0, "R2", tot, 0);
      end
      // R6: hold clears and suppresses
      phase = "R6";
      wait_pulse(t);
      hold_clear = 1'b1;
      count_pulses(200, c);
      check(c == 0, "R6", c, 0);
      hold_clear = 1'b0;
      t = cyc;
      wait_pulse(c);
      check((c - t) >= K * (P_SHORT - 1) && (c - t) <= K * P_SHORT + 2, "R6", c - t, K * P_SHORT);
      // R9: no ticks, no request
      phase = "R9";
      tick_en = 1'b0;
      count_pulses(300, c);
      check(c == 0, "R9", c, 0);
      tick_en = 1'b1;
      wait_pulse(t);
      check(t > 0, "R9", t, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule